// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Controller

This block is the device-side receive path of one isochronous OUT endpoint. A serial interface engine upstream hands it already-decoded events: a pulse when an OUT token addressed to this endpoint is seen, one strobe per payload byte, and an end-of-packet strobe that carries a flag for CRC or bit-stuffing errors. Payload bytes go into a byte FIFO. A local CPU or DMA engine drains that FIFO at the same time as it is being filled. Because of this, a packet longer than the FIFO can pass through it, provided the reader keeps up.

Isochronous traffic has no handshake. The block never answers the host. It keeps a set of sticky status bits that record how each transaction ended: acknowledged, overflowed or corrupted, or timed out. It also records token arrival, packet completion and the almost-full condition. An active-low interrupt line is asserted when any status bit whose enable is set is active. The empty flag and the fill level let software poll one byte at a time.

Top module: `iso_out_rx`

## Requirements
- R1: The FIFO holds DEPTH bytes (128 by default). It returns accepted bytes in arrival order, and `fifo_level_o` counts stored bytes, one edge after each accepted write or read.
- R2: A byte arriving on the same edge as a read of a non-empty, non-full FIFO leaves the level unchanged. A packet of any length therefore passes if it is read concurrently.
- R3: A read of a non-empty FIFO presents the byte on `rd_data_o` after that edge. A read of an empty FIFO leaves `rd_data_o` and the level unchanged.
- R4: `fifo_empty_o` is high exactly when the level is zero.
- R5: An OUT token sets status bit 0 (token seen) on the next edge.
- R6: A byte arriving while the FIFO holds DEPTH bytes is discarded, and status bit 3 (NAK recorded) is set. No packet is sent to the host.
- R7: End of packet sets status bit 1 (packet done). If the packet was clean, it also sets bit 2 (ACK recorded). If the packet had a CRC or bit-stuff error, or lost any byte, it sets bit 3 instead.
- R8: A CRC or bit-stuff error does not stop payload bytes from entering the FIFO.
- R9: After a token, status bit 4 (timeout) is set on the edge that carries the `tmo_limit_i`-th bit tick, unless end of packet comes first.
- R10: Status bit 5 (almost full) is set one edge after the registered level becomes greater than or equal to `af_thresh_i`.
- R11: Status bits are sticky. Writing one to a bit of `stat_clr_i` clears it, and a set on the same edge wins over the clear.
- R12: `irq_n_o` is low exactly when some bit of `stat_o & irq_en_i` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_i | input | 1 | OUT token for this endpoint recognized |
| byte_vld_i | input | 1 | Payload byte strobe |
| byte_i | input | DW | Payload byte |
| eop_i | input | 1 | End of data packet |
| crc_err_i | input | 1 | CRC or bit-stuff error, qualified by eop_i |
| bit_tick_i | input | 1 | One pulse per bit time |
| rd_en_i | input | 1 | Local read strobe |
| af_thresh_i | input | AW | Almost-full threshold |
| tmo_limit_i | input | TW | Timeout in bit times |
| irq_en_i | input | 6 | Interrupt enable per status bit |
| stat_clr_i | input | 6 | Write-one-to-clear per status bit |
| rd_data_o | output | DW | Last byte read |
| fifo_level_o | output | AW+1 | Stored byte count |
| fifo_empty_o | output | 1 | FIFO empty |
| stat_o | output | 6 | Sticky status bits |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Every stored result lands one edge after the stimulus that causes it: the level, the empty flag, read data and the token, packet, NAK, ACK and timeout bits. The almost-full bit is the exception and lands two edges after the write, because it compares the registered level. `irq_n_o` follows `stat_o` and `irq_en_i` with no register. The bench drives and samples 1 ns after each rising edge. Its expected almost-full value at each step is derived from the level held before that edge. Its irq checks are made after a settling delay with no clock edge between.

// File: rtl/iso_out_pkg.sv
package iso_out_pkg;
    localparam int ST_N   = 6;
    localparam int ST_TOK = 0;
    localparam int ST_PKT = 1;
    localparam int ST_ACK = 2;
    localparam int ST_NAK = 3;
    localparam int ST_TMO = 4;
    localparam int ST_AF  = 5;
    typedef logic [ST_N-1:0] stat_t;
endpackage

// File: rtl/iso_byte_fifo.sv
module iso_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
        logic [DW-1:0] rdat;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d     = q;
        do_wr = wr_en && (q.cnt != LW'(DEPTH));
        do_rd = rd_en && (q.cnt != '0);
        if (do_wr) d.wp = bump(q.wp);
        if (do_rd) begin
            d.rp   = bump(q.rp);
            d.rdat = mem[q.rp];
        end
        case ({do_wr, do_rd})
            2'b10:   d.cnt = q.cnt + LW'(1);
            2'b01:   d.cnt = q.cnt - LW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wp] <= wr_data;
    end

    assign rd_data = q.rdat;
    assign level   = q.cnt;
    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == LW'(DEPTH));
endmodule

// File: rtl/iso_eop_timer.sv
module iso_eop_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          tick_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);
    typedef struct packed {
        logic          armed;
        logic [TW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t q, d;
    logic    hit;

    always_comb begin
        d   = q;
        hit = q.armed && tick_i && !stop_i && !start_i &&
              (({1'b0, q.cnt} + (TW+1)'(1)) >= {1'b0, limit_i});
        if (start_i) begin
            d.armed = 1'b1;
            d.cnt   = '0;
        end else if (stop_i || hit) begin
            d.armed = 1'b0;
        end else if (q.armed && tick_i) begin
            d.cnt = q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expire_o = hit;
endmodule

// File: rtl/iso_stat_irq.sv
module iso_stat_irq
    import iso_out_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t set_i,
    input  stat_t clr_i,
    input  stat_t en_i,
    output stat_t stat_o,
    output logic  irq_n_o
);
    typedef struct packed {
        stat_t stat;
    } sreg_st_t;

    sreg_st_t q, d;

    always_comb begin
        d      = q;
        d.stat = (q.stat & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat_o  = q.stat;
    assign irq_n_o = ~|(q.stat & en_i);
endmodule

// File: rtl/iso_out_rx.sv
module iso_out_rx
    import iso_out_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int TW    = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_i,
    input  logic          byte_vld_i,
    input  logic [DW-1:0] byte_i,
    input  logic          eop_i,
    input  logic          crc_err_i,
    input  logic          bit_tick_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] af_thresh_i,
    input  logic [TW-1:0] tmo_limit_i,
    input  logic [ST_N-1:0] irq_en_i,
    input  logic [ST_N-1:0] stat_clr_i,
    output logic [DW-1:0] rd_data_o,
    output logic [LW-1:0] fifo_level_o,
    output logic          fifo_empty_o,
    output logic [ST_N-1:0] stat_o,
    output logic          irq_n_o
);
    typedef struct packed {
        logic lost;
    } top_st_t;

    top_st_t q, d;
    logic    full, drop, bad, expire;
    stat_t   set_v;

    iso_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (byte_vld_i),
        .wr_data (byte_i),
        .rd_en   (rd_en_i),
        .rd_data (rd_data_o),
        .level   (fifo_level_o),
        .empty   (fifo_empty_o),
        .full    (full)
    );

    iso_eop_timer #(.TW(TW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tok_i),
        .stop_i   (eop_i),
        .tick_i   (bit_tick_i),
        .limit_i  (tmo_limit_i),
        .expire_o (expire)
    );

    always_comb begin
        d     = q;
        drop  = byte_vld_i && full;
        bad   = crc_err_i || q.lost || drop;
        set_v = '0;
        set_v[ST_TOK] = tok_i;
        set_v[ST_PKT] = eop_i;
        set_v[ST_ACK] = eop_i && !bad;
        set_v[ST_NAK] = drop || (eop_i && bad);
        set_v[ST_TMO] = expire;
        set_v[ST_AF]  = (fifo_level_o >= {1'b0, af_thresh_i});
        if (tok_i || eop_i) d.lost = 1'b0;
        else if (drop)      d.lost = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    iso_stat_irq stat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .clr_i   (stat_clr_i),
        .en_i    (irq_en_i),
        .stat_o  (stat_o),
        .irq_n_o (irq_n_o)
    );
endmodule

// File: rtl/iso_out_rx_chk.sv
module iso_out_rx_chk
    import iso_out_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tok_i,
    input logic            byte_vld_i,
    input logic            eop_i,
    input logic            rd_en_i,
    input logic [ST_N-1:0] stat_clr_i,
    input logic [DW-1:0]   rd_data_o,
    input logic [LW-1:0]   fifo_level_o,
    input logic            fifo_empty_o,
    input logic [ST_N-1:0] stat_o
);
    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level_o <= LW'(DEPTH));

    // R2
    rw_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && rd_en_i && !fifo_empty_o && fifo_level_o != LW'(DEPTH))
        |=> $stable(fifo_level_o));

    // R3
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && fifo_empty_o) |=> $stable(rd_data_o));

    // R5
    tok_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_i |=> stat_o[ST_TOK]);

    // R6
    drop_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && fifo_level_o == LW'(DEPTH)) |=> stat_o[ST_NAK]);

    // R7
    pkt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_i |=> stat_o[ST_PKT]);

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~stat_clr_i)) == $past(stat_o & ~stat_clr_i)));
endmodule

bind iso_out_rx iso_out_rx_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tok_i        (tok_i),
    .byte_vld_i   (byte_vld_i),
    .eop_i        (eop_i),
    .rd_en_i      (rd_en_i),
    .stat_clr_i   (stat_clr_i),
    .rd_data_o    (rd_data_o),
    .fifo_level_o (fifo_level_o),
    .fifo_empty_o (fifo_empty_o),
    .stat_o       (stat_o)
);

// File: tb/iso_out_rx_tb.sv
module iso_out_rx_tb_top;
    localparam int DEPTH = 128;
    localparam int B_TOK = 0, B_PKT = 1, B_ACK = 2, B_NAK = 3, B_TMO = 4, B_AF = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_i = 0, byte_vld_i = 0, eop_i = 0, crc_err_i = 0;
    logic       bit_tick_i = 0, rd_en_i = 0;
    logic [7:0] byte_i = '0;
    logic [6:0] af_thresh_i = 7'd127;
    logic [9:0] tmo_limit_i = 10'd1000;
    logic [5:0] irq_en_i = '0, stat_clr_i = '0;
    logic [7:0] rd_data_o;
    logic [7:0] fifo_level_o;
    logic       fifo_empty_o;
    logic [5:0] stat_o;
    logic       irq_n_o;

    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    iso_out_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tok_i(tok_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .eop_i(eop_i), .crc_err_i(crc_err_i),
        .bit_tick_i(bit_tick_i), .rd_en_i(rd_en_i), .af_thresh_i(af_thresh_i),
        .tmo_limit_i(tmo_limit_i), .irq_en_i(irq_en_i), .stat_clr_i(stat_clr_i),
        .rd_data_o(rd_data_o), .fifo_level_o(fifo_level_o),
        .fifo_empty_o(fifo_empty_o), .stat_o(stat_o), .irq_n_o(irq_n_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_all();
        stat_clr_i = '1;
        step();
        stat_clr_i = '0;
    endtask

    function automatic logic [7:0] pat_a(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] pat_b(input int i);
        return 8'((i * 13 + 5) & 255);
    endfunction

    initial begin
        #100000;
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // reset state
        chk("R4 reset empty", int'(fifo_empty_o), 1);
        chk("R1 reset level", int'(fifo_level_o), 0);
        chk("R11 reset stat", int'(stat_o), 0);
        chk("R12 reset irq_n", int'(irq_n_o), 1);

        // R5 token
        tok_i = 1; step(); tok_i = 0;
        chk("R5 token bit", int'(stat_o[B_TOK]), 1);

        // R1 R10 fill sweep with threshold 100
        af_thresh_i = 7'd100;
        for (int i = 0; i < DEPTH; i++) begin
            byte_vld_i = 1; byte_i = pat_a(i);
            step();
            chk("R1 level on fill", int'(fifo_level_o), i + 1);
            chk("R10 almost full", int'(stat_o[B_AF]), (i >= 100) ? 1 : 0);
            chk("R4 empty on fill", int'(fifo_empty_o), 0);
        end
        byte_vld_i = 0;

        // R6 overflow drop
        byte_vld_i = 1; byte_i = 8'hEE; step(); byte_vld_i = 0;
        chk("R6 level held", int'(fifo_level_o), DEPTH);
        chk("R6 nak bit", int'(stat_o[B_NAK]), 1);
        eop_i = 1; step(); eop_i = 0;
        chk("R7 pkt bit", int'(stat_o[B_PKT]), 1);
        chk("R7 no ack after drop", int'(stat_o[B_ACK]), 0);

        // R12 irq mask sweep
        for (int en = 0; en < 64; en++) begin
            irq_en_i = 6'(en);
            #0.5;
            chk("R12 irq_n", int'(irq_n_o), ((stat_o & 6'(en)) != 0) ? 0 : 1);
        end
        irq_en_i = '0;

        // R11 write-one-to-clear and set priority
        stat_clr_i = 6'b001000; step(); stat_clr_i = '0;
        chk("R11 nak cleared", int'(stat_o[B_NAK]), 0);
        chk("R11 tok kept", int'(stat_o[B_TOK]), 1);
        stat_clr_i = 6'b001000; byte_vld_i = 1; step();
        stat_clr_i = '0; byte_vld_i = 0;
        chk("R11 set wins", int'(stat_o[B_NAK]), 1);
        chk("R6 second drop level", int'(fifo_level_o), DEPTH);

        // R1 R3 R4 drain
        for (int i = 0; i < DEPTH; i++) begin
            rd_en_i = 1; step();
            chk("R1 order", int'(rd_data_o), int'(pat_a(i)));
            chk("R1 level on drain", int'(fifo_level_o), DEPTH - 1 - i);
        end
        rd_en_i = 0;
        chk("R4 empty after drain", int'(fifo_empty_o), 1);
        rd_en_i = 1; step(); rd_en_i = 0;
        chk("R3 empty read data", int'(rd_data_o), int'(pat_a(DEPTH - 1)));
        chk("R3 empty read level", int'(fifo_level_o), 0);
        clr_all();
        chk("R11 clear all", int'(stat_o), 0);

        // R2 long packet streamed through
        tok_i = 1; step(); tok_i = 0;
        for (int j = 0; j <= 300; j++) begin
            byte_vld_i = (j < 300); byte_i = pat_b(j);
            rd_en_i = (j > 0);
            step();
            if (j > 0) chk("R2 stream data", int'(rd_data_o), int'(pat_b(j - 1)));
            chk("R2 stream level", int'(fifo_level_o), (j < 300) ? 1 : 0);
        end
        byte_vld_i = 0; rd_en_i = 0;
        eop_i = 1; step(); eop_i = 0;
        chk("R7 ack on clean", int'(stat_o[B_ACK]), 1);
        chk("R7 no nak on clean", int'(stat_o[B_NAK]), 0);

        // R8 crc error
        clr_all();
        tok_i = 1; step(); tok_i = 0;
        for (int k = 0; k < 3; k++) begin
            byte_vld_i = 1; byte_i = pat_b(k); step();
        end
        byte_vld_i = 0;
        eop_i = 1; crc_err_i = 1; step(); eop_i = 0; crc_err_i = 0;
        chk("R8 bytes kept", int'(fifo_level_o), 3);
        chk("R7 nak on crc", int'(stat_o[B_NAK]), 1);
        chk("R7 no ack on crc", int'(stat_o[B_ACK]), 0);
        rd_en_i = 1; step(); rd_en_i = 0;
        chk("R8 first byte", int'(rd_data_o), int'(pat_b(0)));
        rd_en_i = 1; step(); step(); rd_en_i = 0;

        // R9 timeout sweep
        for (int lim = 1; lim <= 6; lim++) begin
            clr_all();
            tmo_limit_i = 10'(lim);
            tok_i = 1; step(); tok_i = 0;
            for (int t = 1; t <= lim; t++) begin
                bit_tick_i = 1; step(); bit_tick_i = 0;
                chk("R9 timeout", int'(stat_o[B_TMO]), (t == lim) ? 1 : 0);
            end
        end
        clr_all();
        tmo_limit_i = 10'd4;
        tok_i = 1; step(); tok_i = 0;
        bit_tick_i = 1; repeat (3) step();
        eop_i = 1; step(); eop_i = 0;
        repeat (3) step();
        bit_tick_i = 0;
        chk("R9 eop cancels timeout", int'(stat_o[B_TMO]), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule